// File: doc/BRIEF.md
# Pipeline interlock hazard detector

This block decides, in the same cycle, whether the instruction in the decode stage of a five-stage in-order integer pipeline must be held back. It sorts the decode-stage instruction into an opcode class. From that class it knows whether the instruction reads its first source register (the rs field), its second source register (the rt field), or both.

It then looks at the opcode, function code and destination fields held in the execute, memory and writeback stage registers. From these it finds, for each of the three stages, which register that instruction writes and whether it writes one at all. A link jump writes register 31. A result aimed at register 0 is never treated as live.

The single stall output rises when a source that is actually read equals a destination that is live in any of the three downstream stages. The pipeline control uses it to freeze fetch and decode and to insert a bubble into execute. The block is purely combinational and holds no state.

Top module: `hz_interlock`

## Requirements
- R1: The opcode class is decoded as follows. When op (bits 31:26) is 0, func (bits 5:0) selects the class: 0x08 is jump-register, 0x09 is jump-and-link-register, and any other value is a register-register ALU operation. For other op values: 0x02 is absolute jump, 0x03 is jump-and-link, 0x04 and 0x05 are branch-on-zero, 0x08 to 0x0F are ALU-immediate, 0x23 is load and 0x2B is store. Every remaining op value is an unknown class that reads and writes nothing.
- R2: The destination of a downstream instruction is its rd field (bits 15:11) for register-register ALU operations and its rt field (bits 20:16) for ALU-immediate and load. For jump-and-link and jump-and-link-register the destination is register 31.
- R3: A downstream write is live for ALU, ALU-immediate and load only when their destination is not register 0. It is always live for the two link jumps. It is never live for store, branch, absolute jump, jump-register or an unknown class.
- R4: The decode instruction reads rs (bits 25:21) for ALU, ALU-immediate, load, store, branch-on-zero, jump-register and jump-and-link-register. It does not read rs for absolute jump, jump-and-link or an unknown class.
- R5: The decode instruction reads rt (bits 20:16) only for register-register ALU operations and stores.
- R6: stall is 1 when the decode instruction reads rs and rs equals the live destination of the execute, memory or writeback instruction.
- R7: stall is 1 when the decode instruction reads rt and rt equals the live destination of the execute, memory or writeback instruction. Apart from R6 and R7, stall is 0.
- R8: A bubble carried as an all-zero instruction in a downstream stage (op 0, func 0, rd 0) never causes a stall. With all inputs at zero, stall is 0.
- R9: Each of the execute, memory and writeback stages causes a stall on its own, with the other two stages holding bubbles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dec_insn | input | 32 | Instruction word in the decode stage |
| ex_op | input | 6 | Opcode field of the execute-stage instruction |
| ex_func | input | 6 | Function field of the execute-stage instruction |
| ex_rt | input | 5 | rt field of the execute-stage instruction |
| ex_rd | input | 5 | rd field of the execute-stage instruction |
| ma_op | input | 6 | Opcode field of the memory-stage instruction |
| ma_func | input | 6 | Function field of the memory-stage instruction |
| ma_rt | input | 5 | rt field of the memory-stage instruction |
| ma_rd | input | 5 | rd field of the memory-stage instruction |
| wb_op | input | 6 | Opcode field of the writeback-stage instruction |
| wb_func | input | 6 | Function field of the writeback-stage instruction |
| wb_rt | input | 5 | rt field of the writeback-stage instruction |
| wb_rd | input | 5 | rd field of the writeback-stage instruction |
| stall | output | 1 | Hold decode and fetch, insert a bubble into execute |

## Verification
The sweep puts every producer class in each downstream stage, one stage at a time, against every consumer class. The target register is 0, 5 or 31, placed in either the producer's rd or its rt field and matched to the consumer's rs, its rt or neither. A design that compared rt where rd belongs, or the reverse, would stall on the wrong ALU or load producer. A design that ignored register 0 would freeze the pipe behind writes that are thrown away. A design that forgot the implicit register-31 destination of the link jumps would let a reader of register 31 use a stale value. The jump-register, absolute jump and store consumers expose a read enable that is too broad or too narrow. The all-zero bubble cases show whether an empty stage raises a false stall.

// File: rtl/hz_pkg.sv
package hz_pkg;

   localparam int OP_W = 6;
   localparam int FN_W = 6;

   typedef enum logic [3:0] {
      CL_NONE,
      CL_ALU,
      CL_ALUI,
      CL_LOAD,
      CL_STORE,
      CL_BRZ,
      CL_JMP,
      CL_JLINK,
      CL_JREG,
      CL_JLREG
   } iclass_e;

   localparam logic [OP_W-1:0] OP_SPECIAL = 6'h00;
   localparam logic [OP_W-1:0] OP_JMP     = 6'h02;
   localparam logic [OP_W-1:0] OP_JLINK   = 6'h03;
   localparam logic [OP_W-1:0] OP_BRZ_EQ  = 6'h04;
   localparam logic [OP_W-1:0] OP_BRZ_NE  = 6'h05;
   localparam logic [OP_W-1:0] OP_LOAD    = 6'h23;
   localparam logic [OP_W-1:0] OP_STORE   = 6'h2B;
   localparam logic [FN_W-1:0] FN_JREG    = 6'h08;
   localparam logic [FN_W-1:0] FN_JLREG   = 6'h09;

   function automatic iclass_e classify(input logic [OP_W-1:0] op,
                                        input logic [FN_W-1:0] func);
      iclass_e c;
      if (op == OP_SPECIAL) begin
         if (func == FN_JREG)       c = CL_JREG;
         else if (func == FN_JLREG) c = CL_JLREG;
         else                       c = CL_ALU;
      end else if (op[OP_W-1:3] == 3'b001) begin
         c = CL_ALUI;
      end else begin
         case (op)
            OP_JMP:               c = CL_JMP;
            OP_JLINK:             c = CL_JLINK;
            OP_BRZ_EQ, OP_BRZ_NE: c = CL_BRZ;
            OP_LOAD:              c = CL_LOAD;
            OP_STORE:             c = CL_STORE;
            default:              c = CL_NONE;
         endcase
      end
      return c;
   endfunction

endpackage

// File: rtl/hz_src_decode.sv
module hz_src_decode
   import hz_pkg::*;
#(
   parameter int INSN_W = 32,
   parameter int REG_W  = 5
) (
   input  logic [INSN_W-1:0] insn,
   output logic [REG_W-1:0]  rs,
   output logic [REG_W-1:0]  rt,
   output logic              re1,
   output logic              re2
);

   localparam int OP_LSB = INSN_W - OP_W;
   localparam int RS_LSB = OP_LSB - REG_W;
   localparam int RT_LSB = RS_LSB - REG_W;

   iclass_e cls;

   assign rs  = insn[RS_LSB +: REG_W];
   assign rt  = insn[RT_LSB +: REG_W];
   assign cls = classify(insn[OP_LSB +: OP_W], insn[FN_W-1:0]);

   always_comb begin
      re1 = 1'b0;
      re2 = 1'b0;
      case (cls)
         CL_ALU:   begin re1 = 1'b1; re2 = 1'b1; end
         CL_STORE: begin re1 = 1'b1; re2 = 1'b1; end
         CL_ALUI, CL_LOAD, CL_BRZ, CL_JREG, CL_JLREG: re1 = 1'b1;
         default:  ;
      endcase
   end

   // R5
   always_comb begin
      src_order_chk: assert (!re2 || re1)
         else $error("second source read without first source read");
   end

endmodule

// File: rtl/hz_dst_decode.sv
module hz_dst_decode
   import hz_pkg::*;
#(
   parameter int REG_W         = 5,
   parameter int LINK_REG      = 31,
   parameter bit ZERO_SUPPRESS = 1'b1
) (
   input  logic [OP_W-1:0]  op,
   input  logic [FN_W-1:0]  func,
   input  logic [REG_W-1:0] rt,
   input  logic [REG_W-1:0] rd,
   output logic [REG_W-1:0] ws,
   output logic             we
);

   localparam logic [REG_W-1:0] LINK_IDX = REG_W'(LINK_REG);

   iclass_e cls;
   logic    raw_we;
   logic    zero_dst;

   assign cls = classify(op, func);

   always_comb begin
      ws     = '0;
      raw_we = 1'b0;
      case (cls)
         CL_ALU:             begin ws = rd;       raw_we = 1'b1; end
         CL_ALUI, CL_LOAD:   begin ws = rt;       raw_we = 1'b1; end
         CL_JLINK, CL_JLREG: begin ws = LINK_IDX; raw_we = 1'b1; end
         default:            ;
      endcase
   end

   assign zero_dst = (ws == '0);

   generate
      if (ZERO_SUPPRESS) begin : g_zero_sup
         assign we = raw_we && !zero_dst;

         // R3
         always_comb begin
            dst_zero_chk: assert (!we || ws != '0)
               else $error("live write to register zero");
         end
      end else begin : g_no_sup
         assign we = raw_we;
      end
   endgenerate

endmodule

// File: rtl/hz_match.sv
module hz_match #(
   parameter int REG_W  = 5,
   parameter int N_DOWN = 3
) (
   input  logic [REG_W-1:0]             rs,
   input  logic [REG_W-1:0]             rt,
   input  logic                         re1,
   input  logic                         re2,
   input  logic [N_DOWN-1:0][REG_W-1:0] ws,
   input  logic [N_DOWN-1:0]            we,
   output logic                         stall
);

   logic [N_DOWN-1:0] hit_rs;
   logic [N_DOWN-1:0] hit_rt;

   genvar g;
   generate
      for (g = 0; g < N_DOWN; g++) begin : g_stage
         assign hit_rs[g] = we[g] && (ws[g] == rs);
         assign hit_rt[g] = we[g] && (ws[g] == rt);
      end
   endgenerate

   assign stall = (re1 && (|hit_rs)) || (re2 && (|hit_rt));

endmodule

// File: rtl/hz_interlock.sv
module hz_interlock
   import hz_pkg::*;
#(
   parameter int INSN_W        = 32,
   parameter int REG_W         = 5,
   parameter int LINK_REG      = 31,
   parameter bit ZERO_SUPPRESS = 1'b1
) (
   input  logic [INSN_W-1:0] dec_insn,
   input  logic [OP_W-1:0]   ex_op,
   input  logic [FN_W-1:0]   ex_func,
   input  logic [REG_W-1:0]  ex_rt,
   input  logic [REG_W-1:0]  ex_rd,
   input  logic [OP_W-1:0]   ma_op,
   input  logic [FN_W-1:0]   ma_func,
   input  logic [REG_W-1:0]  ma_rt,
   input  logic [REG_W-1:0]  ma_rd,
   input  logic [OP_W-1:0]   wb_op,
   input  logic [FN_W-1:0]   wb_func,
   input  logic [REG_W-1:0]  wb_rt,
   input  logic [REG_W-1:0]  wb_rd,
   output logic              stall
);

   localparam int N_DOWN = 3;
   localparam int RD_LSB = INSN_W - OP_W - 3 * REG_W;

   generate
      if (RD_LSB < FN_W) begin : g_bad_width
         $error("instruction word too narrow for its fields");
      end
      if (LINK_REG < 1 || LINK_REG >= (1 << REG_W)) begin : g_bad_link
         $error("link register outside the register file");
      end
   endgenerate

   logic [REG_W-1:0]             d_rs, d_rt;
   logic                         d_re1, d_re2;
   logic [N_DOWN-1:0][OP_W-1:0]  s_op;
   logic [N_DOWN-1:0][FN_W-1:0]  s_func;
   logic [N_DOWN-1:0][REG_W-1:0] s_rt, s_rd, s_ws;
   logic [N_DOWN-1:0]            s_we;

   assign s_op   = {wb_op,   ma_op,   ex_op};
   assign s_func = {wb_func, ma_func, ex_func};
   assign s_rt   = {wb_rt,   ma_rt,   ex_rt};
   assign s_rd   = {wb_rd,   ma_rd,   ex_rd};

   hz_src_decode #(.INSN_W(INSN_W), .REG_W(REG_W)) u_src (
      .insn (dec_insn),
      .rs   (d_rs),
      .rt   (d_rt),
      .re1  (d_re1),
      .re2  (d_re2)
   );

   genvar g;
   generate
      for (g = 0; g < N_DOWN; g++) begin : g_dst
         hz_dst_decode #(
            .REG_W         (REG_W),
            .LINK_REG      (LINK_REG),
            .ZERO_SUPPRESS (ZERO_SUPPRESS)
         ) u_dst (
            .op   (s_op[g]),
            .func (s_func[g]),
            .rt   (s_rt[g]),
            .rd   (s_rd[g]),
            .ws   (s_ws[g]),
            .we   (s_we[g])
         );
      end
   endgenerate

   hz_match #(.REG_W(REG_W), .N_DOWN(N_DOWN)) u_match (
      .rs    (d_rs),
      .rt    (d_rt),
      .re1   (d_re1),
      .re2   (d_re2),
      .ws    (s_ws),
      .we    (s_we),
      .stall (stall)
   );

   // R7
   always_comb begin
      stall_cause_chk: assert (!stall || (|s_we))
         else $error("stall with no live downstream write");
   end

   // R6
   always_comb begin
      stall_reader_chk: assert (!stall || d_re1 || d_re2)
         else $error("stall for an instruction that reads nothing");
   end

endmodule

// File: tb/hz_interlock_tb.sv
module hz_interlock_tb;

   logic        clk = 1'b0;
   logic [31:0] dec_insn;
   logic [5:0]  ex_op, ex_func, ma_op, ma_func, wb_op, wb_func;
   logic [4:0]  ex_rt, ex_rd, ma_rt, ma_rd, wb_rt, wb_rd;
   logic        stall;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   hz_interlock u_dut (
      .dec_insn (dec_insn),
      .ex_op (ex_op), .ex_func (ex_func), .ex_rt (ex_rt), .ex_rd (ex_rd),
      .ma_op (ma_op), .ma_func (ma_func), .ma_rt (ma_rt), .ma_rd (ma_rd),
      .wb_op (wb_op), .wb_func (wb_func), .wb_rt (wb_rt), .wb_rd (wb_rd),
      .stall (stall)
   );

   // Eleven sample encodings per R1: index gives op and func.
   localparam int NCLS = 11;
   function automatic logic [5:0] cls_op(input int k);
      case (k)
         0: return 6'h00;  1: return 6'h0C;  2: return 6'h23;  3: return 6'h2B;
         4: return 6'h05;  5: return 6'h02;  6: return 6'h03;  7: return 6'h00;
         8: return 6'h00;  9: return 6'h00;  default: return 6'h3F;
      endcase
   endfunction
   function automatic logic [5:0] cls_fn(input int k);
      case (k)
         0: return 6'h21;  7: return 6'h08;  8: return 6'h09;
         9: return 6'h00;  default: return 6'h15;
      endcase
   endfunction

   // Reference model from R1..R5
   function automatic int kind(input logic [5:0] op, input logic [5:0] fn);
      if (op == 0) return (fn == 8) ? 7 : (fn == 9) ? 8 : 0;
      if (op >= 8 && op <= 15) return 1;
      if (op == 6'h23) return 2;
      if (op == 6'h2B) return 3;
      if (op == 4 || op == 5) return 4;
      if (op == 2) return 5;
      if (op == 3) return 6;
      return 10;
   endfunction
   function automatic logic [4:0] m_ws(input int c, input logic [4:0] rt, input logic [4:0] rd);
      if (c == 0) return rd;
      if (c == 1 || c == 2) return rt;
      if (c == 6 || c == 8) return 5'd31;
      return 5'd0;
   endfunction
   function automatic bit m_we(input int c, input logic [4:0] ws);
      if (c == 0 || c == 1 || c == 2) return ws != 0;
      return (c == 6 || c == 8);
   endfunction
   function automatic bit m_re1(input int c);
      return (c == 0 || c == 1 || c == 2 || c == 3 || c == 4 || c == 7 || c == 8);
   endfunction
   function automatic bit m_re2(input int c);
      return (c == 0 || c == 3);
   endfunction

   task automatic set_stage(input int s, input logic [5:0] op, input logic [5:0] fn,
                            input logic [4:0] rt, input logic [4:0] rd);
      case (s)
         0: begin ex_op = op; ex_func = fn; ex_rt = rt; ex_rd = rd; end
         1: begin ma_op = op; ma_func = fn; ma_rt = rt; ma_rd = rd; end
         default: begin wb_op = op; wb_func = fn; wb_rt = rt; wb_rd = rd; end
      endcase
   endtask

   task automatic clear_all();
      dec_insn = '0;
      for (int s = 0; s < 3; s++) set_stage(s, 6'h00, 6'h00, 5'd0, 5'd0);
   endtask

   task automatic check(input string tag, input bit exp);
      #1;
      checks++;
      if (stall !== exp) begin
         errors++;
         $display("FAIL %s stall actual %0b expected %0b (insn %h)", tag, stall, exp, dec_insn);
      end
   endtask

   initial begin
      clear_all();
      @(negedge clk);
      // R8: all-zero inputs give no stall
      check("R8", 1'b0);

      // R9: same hazard placed in each stage alone, others bubbles
      for (int s = 0; s < 3; s++) begin
         @(negedge clk);
         clear_all();
         dec_insn = {6'h00, 5'd4, 5'd6, 5'd2, 5'd0, 6'h20};
         set_stage(s, 6'h08, 6'h00, 5'd4, 5'd0);
         check("R9", 1'b1);
      end

      // Full sweep: stage x producer x consumer x target x placement
      for (int s = 0; s < 3; s++)
         for (int p = 0; p < NCLS; p++)
            for (int c = 0; c < NCLS; c++)
               for (int ti = 0; ti < 3; ti++)
                  for (int mode = 0; mode < 3; mode++)
                     for (int sel = 0; sel < 2; sel++) begin
                        logic [4:0] t, o, x, crs, crt, prt, prd, ws;
                        int pk, ck;
                        bit we, hs, ht, exp;
                        string tag;
                        t = (ti == 0) ? 5'd0 : (ti == 1) ? 5'd5 : 5'd31;
                        o = (ti == 0) ? 5'd9 : (ti == 1) ? 5'd7 : 5'd3;
                        x = o + 5'd1;
                        crs = (mode == 0) ? t : o;
                        crt = (mode == 1) ? t : o;
                        if (mode == 2) begin crs = o; crt = o; end
                        prd = sel ? t : x;
                        prt = sel ? x : t;
                        @(negedge clk);
                        clear_all();
                        dec_insn = {cls_op(c), crs, crt, 5'd11, 5'd0, cls_fn(c)};
                        if (p == 9) set_stage(s, 6'h00, 6'h00, 5'd0, 5'd0);
                        else set_stage(s, cls_op(p), cls_fn(p), prt, prd);
                        pk = kind(cls_op(p), (p == 9) ? 6'h00 : cls_fn(p));
                        ck = kind(cls_op(c), cls_fn(c));
                        ws = m_ws(pk, (p == 9) ? 5'd0 : prt, (p == 9) ? 5'd0 : prd);
                        we = m_we(pk, ws);
                        hs = m_re1(ck) && we && (ws == crs);
                        ht = m_re2(ck) && we && (ws == crt);
                        exp = hs || ht;
                        // R1 R2 R4 R5 shape the model; tag names the deciding rule
                        if (p == 9)      tag = "R8";
                        else if (hs)     tag = "R6";
                        else if (ht)     tag = "R7";
                        else if (!we)    tag = "R3";
                        else             tag = "R2";
                        check(tag, exp);
                     end
      done = 1'b1;
   end

   initial begin
      for (int i = 0; i < 150000 && !done; i++) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired before sweep finished");
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule